// File: doc/BRIEF.md
# Three-Phase Gate Output Conditioner with Filtered Shutdown

This block sits between a three-phase PWM modulator and the six gate-drive pins of an inverter bridge. It takes six raw switching commands and registers them. Each command is then presented at its pin with a polarity chosen per pin, so that a driver that expects an active-low gate input is served as easily as one that expects an active-high input.

A single external shutdown pin protects the bridge. The pin is synchronized, and its asserted level can be configured as high or low, with low as the default. The pin must then stay asserted through a digital persistence filter of `FILTER_CYCLES` clocks before it acts. Once a shutdown qualifies, a sticky fault flag is set. From that point all six gates sit at their inactive level, and they stay there until software pulses a clear while the shutdown input is seen as inactive. During reset, every gate pin also rests at its inactive level, with the configured polarity taken into account.

Top module: `gate_kill_stage`

## Requirements
- R1: While reset is applied and right after it, every `gateOut[i]` equals `~gatePolarity[i]` (its inactive level) and `faultLatched` is 0.
- R2: With no fault latched, `gateOut[i]` follows `pwmIn[i]` one clock later. A `gatePolarity[i]` of 1 means high-true and gives `gateOut[i] = pwmIn[i]`. A `gatePolarity[i]` of 0 means low-true and gives `gateOut[i] = ~pwmIn[i]`. The bit order is 0 = U high side, 1 = U low side, 2 = V high side, 3 = V low side, 4 = W high side, 5 = W low side.
- R3: When `killActiveHigh` is 0, the shutdown pin is asserted while low. When `killActiveHigh` is 1, it is asserted while high.
- R4: A shutdown assertion sampled on fewer than `FILTER_CYCLES` consecutive clock edges is rejected. `faultLatched` stays 0 and the gates keep following their inputs.
- R5: An assertion sampled on `FILTER_CYCLES` consecutive edges qualifies. `faultLatched` rises on edge `FILTER_CYCLES + 2`, counting from the first edge that samples the pin asserted (34 with the defaults).
- R6: While `faultLatched` is 1, all six gate pins are at their inactive level, whatever `pwmIn` holds.
- R7: Any single sampled inactive cycle restarts the filter count. Two sub-threshold pulses separated by a one-cycle gap do not qualify.
- R8: A `faultClear` sampled while the synchronized shutdown input is inactive clears `faultLatched`, and the gates follow their inputs again on that same edge. A clear sampled while the synchronized input is still asserted is ignored.
- R9: A shutdown held asserted drives the gates inactive within `FILTER_CYCLES + SYNC_STAGES` clocks. With the defaults this is 34 clocks, below the 100-clock bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pwmIn | input | 6 | Raw gate commands from the modulator, 1 = switch on |
| killPin | input | 1 | External shutdown pin, asynchronous |
| killActiveHigh | input | 1 | Shutdown pin polarity: 0 = asserted low, 1 = asserted high |
| gatePolarity | input | 6 | Per-gate polarity: 1 = high-true, 0 = low-true |
| faultClear | input | 1 | Single-cycle request to clear the latched fault |
| gateOut | output | 6 | Conditioned gate-drive outputs |
| faultLatched | output | 1 | Sticky shutdown fault flag |

## Verification
The bound checker checks several rules on every cycle. A latched fault must hold all six pins at their inactive levels. Every rising fault must be preceded by a run of at least `FILTER_CYCLES` asserted pin samples. A falling fault must follow a clear request. A pin held asserted for longer than the latency bound must have produced a fault. The directed scenarios show the exact filter edge: a 31-cycle pulse is rejected and a 32-cycle pulse qualifies on the 34th edge. They also cover restart of the count after a one-cycle gap, a clear ignored while the input is still asserted, and pass-through under mixed per-gate polarity. Only those scenarios establish which cycle each result lands on.

// File: rtl/gk_pkg.sv
package gk_pkg;
  localparam int GATE_COUNT = 6;

  // strobe bundle from control to datapath
  typedef struct packed {
    logic forceOff;   // next-state of the fault: gates off on this edge
    logic loadGates;  // gates may take the new commands on this edge
  } gkCtrl_t;
endpackage

// File: rtl/gk_control.sv
module gk_control #(
  parameter int FILTER_CYCLES = 32,
  parameter int SYNC_STAGES   = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            killPin,
  input  logic            killActiveHigh,
  input  logic            faultClear,
  output gk_pkg::gkCtrl_t ctrl,
  output logic            faultLatched
);
  localparam int CNT_W = (FILTER_CYCLES > 2) ? $clog2(FILTER_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILTER_CYCLES - 1);

  logic                   rawAsserted;
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncAsserted;
  logic [CNT_W-1:0]       runCount;
  logic                   qualify;
  logic                   faultNext;

  // polarity applied ahead of the synchronizer so reset state is "inactive"
  assign rawAsserted = killActiveHigh ? killPin : ~killPin;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= rawAsserted;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[s] <= 1'b0;
          else       syncChain[s] <= syncChain[s-1];
      end
    end
  endgenerate

  assign syncAsserted = syncChain[SYNC_STAGES-1];

  // persistence filter: consecutive synchronized asserted samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  runCount <= '0;
    else if (!syncAsserted)     runCount <= '0;
    else if (runCount != CNT_LAST) runCount <= runCount + 1'b1;
  end

  assign qualify = syncAsserted && (runCount == CNT_LAST);

  always_comb begin
    faultNext = faultLatched;
    if (qualify)                          faultNext = 1'b1;
    else if (faultClear && !syncAsserted) faultNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) faultLatched <= 1'b0;
    else       faultLatched <= faultNext;

  assign ctrl.forceOff  = faultNext;
  assign ctrl.loadGates = ~faultNext;
endmodule

// File: rtl/gk_datapath.sv
module gk_datapath #(
  parameter int GATES = gk_pkg::GATE_COUNT
) (
  input  logic             clk,
  input  logic             rstN,
  input  gk_pkg::gkCtrl_t  ctrl,
  input  logic [GATES-1:0] pwmIn,
  input  logic [GATES-1:0] gatePolarity,
  output logic [GATES-1:0] gateOut
);
  logic [GATES-1:0] gateOn;  // 1 = switch conducting, polarity-free

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              gateOn <= '0;
    else if (ctrl.forceOff) gateOn <= '0;
    else if (ctrl.loadGates) gateOn <= pwmIn;
  end

  generate
    for (genvar g = 0; g < GATES; g++) begin : g_pol
      assign gateOut[g] = gatePolarity[g] ? gateOn[g] : ~gateOn[g];
    end
  endgenerate
endmodule

// File: rtl/gate_kill_stage.sv
module gate_kill_stage #(
  parameter int FILTER_CYCLES = 32,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [5:0] pwmIn,
  input  logic       killPin,
  input  logic       killActiveHigh,
  input  logic [5:0] gatePolarity,
  input  logic       faultClear,
  output logic [5:0] gateOut,
  output logic       faultLatched
);
  gk_pkg::gkCtrl_t ctrl;

  gk_control #(.FILTER_CYCLES(FILTER_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .killPin(killPin), .killActiveHigh(killActiveHigh),
    .faultClear(faultClear), .ctrl(ctrl), .faultLatched(faultLatched)
  );

  gk_datapath #(.GATES(gk_pkg::GATE_COUNT)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .pwmIn(pwmIn),
    .gatePolarity(gatePolarity), .gateOut(gateOut)
  );
endmodule

// File: rtl/gate_kill_stage_chk.sv
module gate_kill_stage_chk #(
  parameter int FILTER_CYCLES = 32,
  parameter int SYNC_STAGES   = 2
) (
  input logic       clk,
  input logic       rstN,
  input logic       killPin,
  input logic       killActiveHigh,
  input logic [5:0] gatePolarity,
  input logic       faultClear,
  input logic [5:0] gateOut,
  input logic       faultLatched
);
  localparam int RUN_MAX = FILTER_CYCLES + SYNC_STAGES + 2;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  logic             pinAsserted;
  logic [RUN_W-1:0] curRun;
  logic [RUN_W-1:0] lastRun;

  assign pinAsserted = killActiveHigh ? killPin : ~killPin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curRun  <= '0;
      lastRun <= '0;
    end else if (pinAsserted) begin
      if (curRun != RUN_W'(RUN_MAX)) curRun <= curRun + 1'b1;
      lastRun <= (curRun != RUN_W'(RUN_MAX)) ? curRun + 1'b1 : curRun;
    end else begin
      curRun <= '0;
    end
  end

  // R1
  reset_inactive_chk: assert property (@(posedge clk)
    !rstN |-> (gateOut == ~gatePolarity && !faultLatched));

  // R6
  fault_forces_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultLatched |-> gateOut == ~gatePolarity);

  // R5
  filter_min_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultLatched) |-> lastRun >= RUN_W'(FILTER_CYCLES));

  // R8
  clear_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultLatched) |-> $past(faultClear));

  // R9
  kill_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curRun >= RUN_W'(FILTER_CYCLES + SYNC_STAGES)) |-> faultLatched);
endmodule

bind gate_kill_stage gate_kill_stage_chk #(
  .FILTER_CYCLES(FILTER_CYCLES), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rstN(rstN), .killPin(killPin), .killActiveHigh(killActiveHigh),
  .gatePolarity(gatePolarity), .faultClear(faultClear),
  .gateOut(gateOut), .faultLatched(faultLatched)
);

// File: tb/gate_kill_stage_test.sv
`timescale 1ns/1ps
module gate_kill_stage_test;
  localparam int FILT = 32;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] pwmIn = '0;
  logic       killPin = 1'b1;
  logic       killActiveHigh = 1'b0;
  logic [5:0] gatePolarity = 6'b101010;
  logic       faultClear = 1'b0;
  logic [5:0] gateOut;
  logic       faultLatched;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  gate_kill_stage #(.FILTER_CYCLES(FILT), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .killPin(killPin),
    .killActiveHigh(killActiveHigh), .gatePolarity(gatePolarity),
    .faultClear(faultClear), .gateOut(gateOut), .faultLatched(faultLatched)
  );

  function automatic logic [5:0] passVal(logic [5:0] v, logic [5:0] p);
    return ~(v ^ p);
  endfunction

  task automatic checkGate(string req, logic [5:0] exp);
    total++;
    if (gateOut !== exp) begin
      bad++;
      $display("FAIL %s gateOut actual=%b expected=%b", req, gateOut, exp);
    end
  endtask

  task automatic checkFault(string req, logic exp);
    total++;
    if (faultLatched !== exp) begin
      bad++;
      $display("FAIL %s faultLatched actual=%b expected=%b", req, faultLatched, exp);
    end
  endtask

  function automatic logic idleLevel();
    return killActiveHigh ? 1'b0 : 1'b1;
  endfunction

  // clears a latched fault with the input inactive
  task automatic recover();
    killPin = idleLevel();
    repeat (4) @(negedge clk);
    faultClear = 1'b1;
    @(negedge clk);
    faultClear = 1'b0;
  endtask

  task automatic testReset();
    // R1: outputs inactive while in reset
    @(negedge clk);
    checkGate("R1", ~gatePolarity);
    checkFault("R1", 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    checkGate("R1", ~gatePolarity);
  endtask

  task automatic testPassThrough();
    logic [5:0] pats [4] = '{6'b111111, 6'b000000, 6'b100101, 6'b011010};
    logic [5:0] pols [2] = '{6'b101010, 6'b110011};
    foreach (pols[j]) begin
      gatePolarity = pols[j];
      foreach (pats[i]) begin
        pwmIn = pats[i];
        @(negedge clk);
        // R2: mixed polarity pass-through
        checkGate("R2", passVal(pats[i], pols[j]));
      end
    end
    gatePolarity = 6'b101010;
    pwmIn = 6'b111111;
    @(negedge clk);
  endtask

  task automatic testShortPulse();
    killPin = ~idleLevel();
    repeat (FILT - 1) @(negedge clk);
    killPin = idleLevel();
    repeat (6) @(negedge clk);
    // R4: 31-cycle pulse rejected
    checkFault("R4", 1'b0);
    pwmIn = 6'b010101;
    @(negedge clk);
    checkGate("R4", passVal(6'b010101, gatePolarity));
    pwmIn = 6'b111111;
    @(negedge clk);
  endtask

  task automatic testExactPulse(string req);
    killPin = ~idleLevel();
    for (int i = 1; i <= FILT + 2; i++) begin
      @(negedge clk);
      if (i == FILT) killPin = idleLevel();
      if (i == FILT + 1) begin
        checkFault(req, 1'b0);
        checkGate(req, passVal(pwmIn, gatePolarity));
      end
    end
    // R5 / R9: fault on edge FILT+2 and gates off
    checkFault(req, 1'b1);
    checkGate("R9", ~gatePolarity);
    pwmIn = 6'b011001;
    @(negedge clk);
    // R6: new commands ignored while fault latched
    checkGate("R6", ~gatePolarity);
    pwmIn = 6'b111111;
  endtask

  task automatic testClear();
    killPin = ~idleLevel();
    repeat (FILT + 6) @(negedge clk);
    checkFault("R5", 1'b1);
    faultClear = 1'b1;
    @(negedge clk);
    faultClear = 1'b0;
    // R8: clear ignored while input asserted
    checkFault("R8", 1'b1);
    killPin = idleLevel();
    faultClear = 1'b1;
    @(negedge clk);
    faultClear = 1'b0;
    // R8: synchronized input still asserted, clear ignored
    checkFault("R8", 1'b1);
    checkGate("R8", ~gatePolarity);
    repeat (3) @(negedge clk);
    faultClear = 1'b1;
    @(negedge clk);
    faultClear = 1'b0;
    // R8: clear accepted, gates resume on the same edge
    checkFault("R8", 1'b0);
    checkGate("R8", passVal(pwmIn, gatePolarity));
  endtask

  task automatic testGap();
    killPin = ~idleLevel();
    repeat (20) @(negedge clk);
    killPin = idleLevel();
    @(negedge clk);
    killPin = ~idleLevel();
    repeat (20) @(negedge clk);
    killPin = idleLevel();
    repeat (6) @(negedge clk);
    // R7: gap restarts the count
    checkFault("R7", 1'b0);
    checkGate("R7", passVal(pwmIn, gatePolarity));
  endtask

  task automatic testActiveHigh();
    killActiveHigh = 1'b1;
    killPin = 1'b0;
    repeat (FILT + 6) @(negedge clk);
    // R3: low pin is idle when active-high
    checkFault("R3", 1'b0);
    testExactPulse("R3");
    recover();
    checkFault("R3", 1'b0);
    killActiveHigh = 1'b0;
    killPin = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    testPassThrough();
    testShortPulse();
    testExactPulse("R5");
    recover();
    testClear();
    testGap();
    testActiveHigh();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule